// File: doc/BRIEF.md
# DDR Write-Sequencing Command Scheduler

This block sits between a host request queue and the command bus of a double-data-rate SDRAM. It decides on which clock cycle each command goes out after a write burst, whether that command is a further WRITE, a READ or a PRECHARGE. Each WRITE request carries the number of data pairs the host actually wants from it. The scheduler uses that count to find the last wanted data cycle of the burst, and it gates every later command against it. A burst can therefore be chained seamlessly to another WRITE, or cut short by a WRITE, READ or PRECHARGE. Any pair that falls past the wanted count is marked with a data-mask strobe, so that it never reaches the array.

The host side uses a valid/ready handshake. `req_ready` reflects whether the command currently presented (type and bank) may go out in this cycle. An accepted request is driven onto the registered command bus on the next cycle. When nothing is accepted, a no-operation code is driven. The scheduler also follows the data-pair slots of the write burst in flight, and it blocks any command to a bank that has just been precharged until the precharge recovery time has elapsed. The burst length, the bank count and the three recovery times are parameters counted in clock cycles.

Top module: `ddr_wr_sched`

## Requirements
- R1: A request accepted in cycle h (req_valid and req_ready both high) appears on `ddr_cmd` in cycle h+1 with its bank on `ddr_bank`. The bus codes are 1 = WRITE, 2 = READ and 3 = PRECHARGE, for request codes 0 = WRITE, 1 = READ and 2 = PRECHARGE. In every cycle that follows no acceptance, `ddr_cmd` is 0 (no-operation).
- R2: After a WRITE accepted in cycle h with an effective wanted count of W pairs, another WRITE is accepted no earlier than cycle h+W. With W = 1, this is the very next cycle.
- R3: After that WRITE, a READ is accepted no earlier than cycle h+W+TWTR.
- R4: After that WRITE, a PRECHARGE is accepted no earlier than cycle h+W+TWR.
- R5: A WRITE accepted in cycle h drives its BL/2 pair slots in cycles h+2 through h+1+BL/2. In those cycles `wr_pair_act` is high and `wr_pair_idx` counts 0, 1, and so on. The slots of a newer WRITE replace the remaining slots of an older burst, with no idle cycle between the two bursts when R2 is met exactly.
- R6: `wr_dm` is high exactly on the pair slots whose index is at least W, and it is low in every other cycle.
- R7: After a PRECHARGE to bank b is accepted in cycle h, no command to bank b is accepted before cycle h+TRP. Other banks are not affected.
- R8: A `req_pairs` value of 0, or a value above BL/2, is treated as W = BL/2, which is a full burst with no masked pair.
- R9: While reset is held and on release, `ddr_cmd` is 0, `wr_pair_act` and `wr_dm` are low, and all timing state is clear, so any legal command is accepted in the first cycle after reset.
- R10: Request code 3 is reserved and is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Presented request may issue this cycle |
| req_cmd | input | 2 | Request type: 0 WRITE, 1 READ, 2 PRECHARGE, 3 reserved |
| req_bank | input | $clog2(NBANK) | Target bank |
| req_pairs | input | $clog2(BL/2+1) | Wanted data pairs for a WRITE |
| ddr_cmd | output | 3 | Command bus code: 0 NOP, 1 WRITE, 2 READ, 3 PRECHARGE |
| ddr_bank | output | $clog2(NBANK) | Bank of the driven command |
| wr_pair_act | output | 1 | A write data-pair slot is being driven |
| wr_pair_idx | output | max(1,$clog2(BL/2)) | Index of the current pair within its burst |
| wr_dm | output | 1 | Mask the current data pair |

## Verification
Two functions can land in the same cycle: the takeover of the data-pair slots by a chained WRITE, and the masking of the trailing pairs of the burst being replaced. The bench provokes this collision with WRITEs whose wanted count is shorter than the burst, followed immediately by another WRITE. It also issues random streams in which READs and PRECHARGEs arrive while masked pairs are still in flight. A behavioural model keeps a per-cycle table of expected slots and masks. In that table a newer burst overwrites the future entries of the older one. Each cycle, the outputs are compared against that table: a stray high `wr_dm` or a missing slot index at the junction between the two bursts shows up as a mismatch.

// File: rtl/ddr_ws_pkg.sv
package ddr_ws_pkg;

  typedef enum logic [1:0] {
    REQ_WRITE     = 2'd0,
    REQ_READ      = 2'd1,
    REQ_PRECHARGE = 2'd2,
    REQ_RSVD      = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    BUS_NOP       = 3'd0,
    BUS_WRITE     = 3'd1,
    BUS_READ      = 3'd2,
    BUS_PRECHARGE = 3'd3
  } bus_cmd_e;

  function automatic bus_cmd_e to_bus(input req_kind_e k);
    case (k)
      REQ_WRITE:     return BUS_WRITE;
      REQ_READ:      return BUS_READ;
      REQ_PRECHARGE: return BUS_PRECHARGE;
      default:       return BUS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/ws_gap_counter.sv
module ws_gap_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          idle
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/ws_bank_guard.sv
module ws_bank_guard #(
  parameter int NBANK = 4,
  parameter int CW    = 4,
  parameter int TRP   = 3,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pre_fire,
  input  logic [BW-1:0]    pre_bank,
  output logic [NBANK-1:0] bank_idle
);
  localparam logic [CW-1:0] RP_LOAD = CW'(TRP - 1);

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    logic hit;
    assign hit = pre_fire && (pre_bank == BW'(gb));
    ws_gap_counter #(.CW(CW)) rp_cnt_i (
      .clk      (clk),
      .rst      (rst),
      .load     (hit),
      .load_val (RP_LOAD),
      .idle     (bank_idle[gb])
    );
  end
endmodule

// File: rtl/ws_pair_tracker.sv
module ws_pair_tracker #(
  parameter int NPAIR = 4,
  localparam int PW   = $clog2(NPAIR + 1),
  localparam int IW   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] start_want,
  output logic          pair_act,
  output logic [IW-1:0] pair_idx,
  output logic          pair_mask
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NPAIR - 1);

  logic          stg_v;
  logic [PW-1:0] stg_want;
  logic [PW-1:0] want_q;
  logic [PW-1:0] nxt_idx;

  assign nxt_idx = PW'(pair_idx) + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v     <= 1'b0;
      stg_want  <= '0;
      want_q    <= '0;
      pair_act  <= 1'b0;
      pair_idx  <= '0;
      pair_mask <= 1'b0;
    end else begin
      stg_v    <= start;
      stg_want <= start_want;
      if (stg_v) begin
        pair_act  <= 1'b1;
        pair_idx  <= '0;
        want_q    <= stg_want;
        pair_mask <= 1'b0;
      end else if (pair_act && (pair_idx != LAST_IDX)) begin
        pair_idx  <= pair_idx + 1'b1;
        pair_mask <= (nxt_idx >= want_q);
      end else begin
        pair_act  <= 1'b0;
        pair_idx  <= '0;
        pair_mask <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddr_wr_sched.sv
module ddr_wr_sched
  import ddr_ws_pkg::*;
#(
  parameter int BL    = 8,
  parameter int NBANK = 4,
  parameter int TWTR  = 2,
  parameter int TWR   = 3,
  parameter int TRP   = 3,
  localparam int NPAIR = BL / 2,
  localparam int PW    = $clog2(NPAIR + 1),
  localparam int IW    = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int BW    = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_cmd,
  input  logic [BW-1:0] req_bank,
  input  logic [PW-1:0] req_pairs,
  output logic [2:0]    ddr_cmd,
  output logic [BW-1:0] ddr_bank,
  output logic          wr_pair_act,
  output logic [IW-1:0] wr_pair_idx,
  output logic          wr_dm
);
  localparam int TMAX  = (TWTR > TWR) ? TWTR : TWR;
  localparam int SPAN0 = NPAIR + TMAX;
  localparam int SPAN  = (TRP > SPAN0) ? TRP : SPAN0;
  localparam int CW    = $clog2(SPAN + 1);

  req_kind_e        kind;
  logic [PW-1:0]    want_eff;
  logic [CW-1:0]    want_w;
  logic             fire, fire_wr, fire_pre;
  logic             wtw_idle, wtr_idle, wr_idle;
  logic [NBANK-1:0] bank_idle;
  logic             type_ok;

  assign kind     = req_kind_e'(req_cmd);
  assign want_eff = ((req_pairs == '0) || (req_pairs > PW'(NPAIR))) ? PW'(NPAIR) : req_pairs;
  assign want_w   = CW'(want_eff);

  always_comb begin
    case (kind)
      REQ_WRITE:     type_ok = wtw_idle;
      REQ_READ:      type_ok = wtr_idle;
      REQ_PRECHARGE: type_ok = wr_idle;
      default:       type_ok = 1'b0;
    endcase
  end

  assign req_ready = !rst && type_ok && bank_idle[req_bank];
  assign fire      = req_valid && req_ready;
  assign fire_wr   = fire && (kind == REQ_WRITE);
  assign fire_pre  = fire && (kind == REQ_PRECHARGE);

  ws_gap_counter #(.CW(CW)) wtw_i (
    .clk (clk), .rst (rst), .load (fire_wr),
    .load_val (want_w - CW'(1)), .idle (wtw_idle)
  );
  ws_gap_counter #(.CW(CW)) wtr_i (
    .clk (clk), .rst (rst), .load (fire_wr),
    .load_val (want_w + CW'(TWTR) - CW'(1)), .idle (wtr_idle)
  );
  ws_gap_counter #(.CW(CW)) wr_i (
    .clk (clk), .rst (rst), .load (fire_wr),
    .load_val (want_w + CW'(TWR) - CW'(1)), .idle (wr_idle)
  );

  ws_bank_guard #(.NBANK(NBANK), .CW(CW), .TRP(TRP)) guard_i (
    .clk       (clk),
    .rst       (rst),
    .pre_fire  (fire_pre),
    .pre_bank  (req_bank),
    .bank_idle (bank_idle)
  );

  ws_pair_tracker #(.NPAIR(NPAIR)) pairs_i (
    .clk        (clk),
    .rst        (rst),
    .start      (fire_wr),
    .start_want (want_eff),
    .pair_act   (wr_pair_act),
    .pair_idx   (wr_pair_idx),
    .pair_mask  (wr_dm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ddr_cmd  <= BUS_NOP;
      ddr_bank <= '0;
    end else begin
      ddr_cmd  <= fire ? to_bus(kind) : BUS_NOP;
      ddr_bank <= fire ? req_bank : '0;
    end
  end
endmodule

// File: rtl/ddr_wr_sched_chk.sv
module ddr_wr_sched_chk #(
  parameter int BL    = 8,
  parameter int NBANK = 4,
  parameter int TRP   = 3,
  localparam int NPAIR = BL / 2,
  localparam int PW    = $clog2(NPAIR + 1),
  localparam int IW    = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int BW    = $clog2(NBANK)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_cmd,
  input logic [BW-1:0] req_bank,
  input logic [PW-1:0] req_pairs,
  input logic [2:0]    ddr_cmd,
  input logic [BW-1:0] ddr_bank,
  input logic          wr_pair_act,
  input logic [IW-1:0] wr_pair_idx,
  input logic          wr_dm
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1
  cmd_follows_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (ddr_cmd == ({1'b0, $past(req_cmd)} + 3'd1)) && (ddr_bank == $past(req_bank)));

  // R1
  nop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> (ddr_cmd == 3'd0));

  // R10
  rsvd_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_cmd == 2'd3) |-> !req_ready);

  // R6
  mask_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dm |-> wr_pair_act);

  // R5
  slot_start_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_cmd == 2'd0) |-> ##2 (wr_pair_act && wr_pair_idx == '0 && !wr_dm));

  // R2
  chain_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_cmd == 2'd0 && req_pairs == PW'(2) && NPAIR >= 2)
      |=> !(req_ready && req_cmd == 2'd0));

  // R7
  bank_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_cmd == 2'd2 && TRP > 1)
      |=> !(req_ready && req_bank == $past(req_bank)));
endmodule

bind ddr_wr_sched ddr_wr_sched_chk #(.BL(BL), .NBANK(NBANK), .TRP(TRP)) chk_i (.*);

// File: tb/ddr_wr_sched_tb_top.sv
module ddr_wr_sched_tb_top;
  localparam int BL    = 8;
  localparam int NBANK = 4;
  localparam int TWTR  = 2;
  localparam int TWR   = 3;
  localparam int TRP   = 3;
  localparam int NP    = BL / 2;
  localparam int PW    = $clog2(NP + 1);
  localparam int IW    = (NP > 1) ? $clog2(NP) : 1;
  localparam int BW    = $clog2(NBANK);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_cmd = 2'd0;
  logic [BW-1:0] req_bank = '0;
  logic [PW-1:0] req_pairs = '0;
  logic [2:0]    ddr_cmd;
  logic [BW-1:0] ddr_bank;
  logic          wr_pair_act;
  logic [IW-1:0] wr_pair_idx;
  logic          wr_dm;

  always #5 clk = ~clk;

  ddr_wr_sched #(.BL(BL), .NBANK(NBANK), .TWTR(TWTR), .TWR(TWR), .TRP(TRP)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int last_w_h = -1000, last_w_want = 0;
  int last_pre [NBANK];
  int    e_cmd  [int];
  int    e_bank [int];
  int    e_idx  [int];
  bit    e_dm   [int];
  string e_tag  [int];

  typedef struct { int cmd; int bank; int pairs; int gap; } req_t;
  req_t rq [$];

  task automatic chk(input bit ok, input string tag, input string what, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, a, e, cyc);
    end
  endtask

  function automatic int eff(input int p);
    return (p == 0 || p > NP) ? NP : p;
  endfunction

  function automatic bit mdl_ready(input int c, input int b, output string tag);
    int lim;
    tag = "R2";
    if (c == 3) begin tag = "R10"; return 1'b0; end
    if (cyc < last_pre[b] + TRP) begin tag = "R7"; return 1'b0; end
    case (c)
      0: begin lim = last_w_h + last_w_want;        tag = "R2"; end
      1: begin lim = last_w_h + last_w_want + TWTR; tag = "R3"; end
      default: begin lim = last_w_h + last_w_want + TWR; tag = "R4"; end
    endcase
    return cyc >= lim;
  endfunction

  task automatic check_outputs();
    int ec;
    bit ea;
    ec = e_cmd.exists(cyc) ? e_cmd[cyc] : 0;
    chk(ddr_cmd == 3'(ec), "R1", "ddr_cmd", int'(ddr_cmd), ec);
    if (ec != 0) chk(ddr_bank == BW'(e_bank[cyc]), "R1", "ddr_bank", int'(ddr_bank), e_bank[cyc]);
    ea = e_idx.exists(cyc);
    chk(wr_pair_act == ea, "R5", "wr_pair_act", int'(wr_pair_act), int'(ea));
    if (ea) begin
      chk(wr_pair_idx == IW'(e_idx[cyc]), "R5", "wr_pair_idx", int'(wr_pair_idx), e_idx[cyc]);
      chk(wr_dm == e_dm[cyc], e_tag[cyc], "wr_dm", int'(wr_dm), int'(e_dm[cyc]));
    end else
      chk(wr_dm == 1'b0, "R6", "wr_dm idle", int'(wr_dm), 0);
  endtask

  task automatic step(input bit v, input int c, input int b, input int p, output bit acc);
    bit er;
    string tg;
    int w;
    @(negedge clk);
    check_outputs();
    req_valid = v; req_cmd = 2'(c); req_bank = BW'(b); req_pairs = PW'(p);
    #1;
    er = mdl_ready(c, b, tg);
    chk(req_ready == er, tg, "req_ready", int'(req_ready), int'(er));
    acc = v && er;
    if (acc) begin
      e_cmd[cyc + 1]  = c + 1;
      e_bank[cyc + 1] = b;
      if (c == 0) begin
        w = eff(p);
        for (int k = 0; k < NP; k++) begin
          e_idx[cyc + 2 + k] = k;
          e_dm[cyc + 2 + k]  = (k >= w);
          e_tag[cyc + 2 + k] = (p == 0 || p > NP) ? "R8" : "R6";
        end
        last_w_h = cyc; last_w_want = w;
      end else if (c == 2) last_pre[b] = cyc;
    end
    cyc++;
  endtask

  task automatic add(input int c, input int b, input int p, input int g);
    req_t r;
    r.cmd = c; r.bank = b; r.pairs = p; r.gap = g;
    rq.push_back(r);
  endtask

  // watchdog: counts as a failed check
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit acc;
    for (int i = 0; i < NBANK; i++) last_pre[i] = -1000;
    repeat (3) @(posedge clk);
    // R9: state held in reset
    #1;
    chk(ddr_cmd == 3'd0 && !wr_pair_act && !wr_dm && !req_ready, "R9", "reset outputs",
        int'({ddr_cmd, wr_pair_act, wr_dm, req_ready}), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R9", "ready after reset", int'(req_ready), 1);

    // directed: full chain, short chain, truncation by READ and PRECHARGE
    add(0, 0, 4, 0); add(0, 0, 4, 0); add(1, 0, 0, 0);          // R2 R3
    add(0, 1, 2, 0); add(0, 1, 1, 0); add(0, 1, 3, 0);          // R5 R6 chained short
    add(1, 1, 0, 0);                                             // R3 truncating read
    add(0, 2, 1, 0); add(2, 2, 0, 0); add(0, 2, 4, 0);          // R4 R7
    add(2, 3, 0, 0); add(1, 0, 0, 0); add(0, 3, 2, 0);          // R7 other bank free
    add(0, 0, 0, 0); add(0, 0, 7, 0); add(1, 2, 0, 2);          // R8
    for (int i = 0; i < 300; i++)
      add(int'($urandom % 3), int'($urandom % NBANK), int'($urandom % 8), int'($urandom % 3));

    while (rq.size() > 0) begin
      req_t r;
      r = rq.pop_front();
      for (int g = 0; g < r.gap; g++)
        step(1'b0, int'($urandom % 4), int'($urandom % NBANK), int'($urandom % 8), acc);
      acc = 1'b0;
      while (!acc) step(1'b1, r.cmd, r.bank, r.pairs, acc);
    end
    for (int i = 0; i < NP + 4; i++) step(1'b0, 3, 0, 0, acc);   // R10 reserved code idle

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule